// File: doc/BRIEF.md
# Cascadable Configuration Memory Read Sequencer

This block is the read side of a configuration store that an external configuration clock steps through. It holds a small content array and a word address counter. While it is selected and not held in reset, each rising clock edge moves it on by one item. In serial mode an item is one bit, taken most significant bit first. In parallel mode an item is a whole byte. The data pins are modelled as a value vector plus a per-lane output-enable vector, so a shared bus can be built without tri-state nets.

Several stores can be chained on one clock and one data bus. The active-low chip-enable-out of one device drives the active-low chip enable of the next. When the first device has delivered its last item, the following clock floats its data lanes and pulls chip-enable-out low, and the next device takes over the bus. A combined output-enable/reset input clears the counter and floats the outputs. The serial/parallel choice is a register bit that can be loaded only while that input holds the block in reset.

Top module: `cfgrd_top`

## Requirements
- R1: On a rising clock edge with `ce_n` low and `oe_rst_n` high, the read position advances by exactly one item (one bit in serial mode, one byte in parallel mode); otherwise it does not advance.
- R2: A clock edge with `oe_rst_n` low returns the read position to word 0, bit 7. While `oe_rst_n` is low, `dout_en` is 0 and `ceo_n` is high. `ceo_n` stays high after `oe_rst_n` returns high until the last item is passed again.
- R3: While `ce_n` is high, `dout_en` is 0 whatever `oe_rst_n` is. A clock edge in that state returns the read position to word 0, bit 7.
- R4: `ceo_n` is low exactly when `ce_n` is low, `oe_rst_n` is high, and the counter has gone past the terminal count (address DEPTH-1).
- R5: The clock edge that follows the last item drops `dout_en` to 0 and `ceo_n` low in the same cycle, so a chained device whose `ce_n` is driven by `ceo_n` presents its own item 0 at once.
- R6: Once past the terminal count, further clocks leave `dout_en` at 0 and `ceo_n` low. The counter does not wrap to address 0.
- R7: In serial mode, `dout_en` is 8'h01 when presenting. `dout[0]` carries bit (7 - b) of the current byte, where b counts 0..7, and the word address steps when b wraps from 7 to 0.
- R8: In parallel mode, `dout_en` is 8'hFF when presenting and `dout[7:0]` carries the whole current byte.
- R9: An active-low `rst_n` clears the counter and selects serial mode (mode bit 0). This holds even if parallel mode was selected before.
- R10: A clock edge with `mode_wr` high and `oe_rst_n` low loads `mode_par` as the mode bit (1 = parallel). With `oe_rst_n` high, `mode_wr` is ignored.
- R11: The byte stored at address a is (a*MUL + SEED) mod 256, with MUL and SEED parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ce_n | input | 1 | Chip enable, active low; high means standby |
| oe_rst_n | input | 1 | Output enable when high, counter reset when low |
| mode_wr | input | 1 | Load strobe for the mode bit |
| mode_par | input | 1 | Mode value to load: 1 parallel, 0 serial |
| dout | output | 8 | Data value per lane (0 when a lane is not enabled) |
| dout_en | output | 8 | Per-lane output enable; 0 means high impedance |
| ceo_n | output | 1 | Chip-enable-out to the next chained device, active low |

## Verification
The outputs depend combinationally on `ce_n`, `oe_rst_n` and the registered read position. A change to the enable inputs therefore shows in the same cycle, while a step of the read position, a cleared counter or a loaded mode bit shows only after the next rising edge. The bench changes inputs 1 ns after an edge and samples 1 ns later. It counts edges with `ce_n` low and `oe_rst_n` high to work out which item each of two chained devices should present. Each expected bit, byte, lane mask and chip-enable-out level is computed arithmetically from that count and the content formula, and sampled in the cycle it is due.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = 3;

    typedef enum logic {
        MODE_SER = 1'b0,
        MODE_PAR = 1'b1
    } out_mode_e;

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

endpackage

// File: rtl/cfgrd_rom.sv
module cfgrd_rom
    import cfgrd_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int MUL   = 37,
    parameter int SEED  = 90
) (
    input  logic [AW-1:0]     addr_i,
    output logic [BYTE_W-1:0] data_o
);

    logic [BYTE_W-1:0] cells_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int VAL = (g * MUL + SEED) % 256;
        assign cells_w[g] = BYTE_W'(VAL);
    end

    always_comb begin
        data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr_i == AW'(i)) begin
                data_o = cells_w[i];
            end
        end
    end

endmodule

// File: rtl/cfgrd_seq.sv
module cfgrd_seq
    import cfgrd_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_n,
    input  logic                 oe_rst_n,
    input  logic                 mode_wr,
    input  logic                 mode_par,
    output logic [AW-1:0]        addr_o,
    output logic [BIT_CNT_W-1:0] bit_o,
    output out_mode_e            mode_o,
    output logic                 active_o,
    output logic                 ceo_n
);

    localparam logic [AW-1:0] TERM = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0]        addr;
        logic [BIT_CNT_W-1:0] bitc;
        logic                 past_tc;
        out_mode_e            mode;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       sel_w;
    logic       item_end_w;

    always_comb begin
        st_d       = st_q;
        sel_w      = !ce_n && oe_rst_n;
        item_end_w = (st_q.mode == MODE_PAR) || (st_q.bitc == LAST_BIT);

        if (mode_wr && !oe_rst_n) begin
            st_d.mode = out_mode_e'(mode_par);
        end

        if (!sel_w) begin
            st_d.addr    = '0;
            st_d.bitc    = '0;
            st_d.past_tc = 1'b0;
        end else if (!st_q.past_tc) begin
            if (item_end_w) begin
                st_d.bitc = '0;
                if (st_q.addr == TERM) begin
                    st_d.past_tc = 1'b1;
                end else begin
                    st_d.addr = st_q.addr + AW'(1);
                end
            end else begin
                st_d.bitc = st_q.bitc + BIT_CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, bitc: '0, past_tc: 1'b0, mode: MODE_SER};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o   = st_q.addr;
    assign bit_o    = st_q.bitc;
    assign mode_o   = st_q.mode;
    assign active_o = sel_w && !st_q.past_tc;
    assign ceo_n    = !(sel_w && st_q.past_tc);

endmodule

// File: rtl/cfgrd_outmux.sv
module cfgrd_outmux
    import cfgrd_pkg::*;
(
    input  out_mode_e            mode_i,
    input  logic                 active_i,
    input  logic [BYTE_W-1:0]    byte_i,
    input  logic [BIT_CNT_W-1:0] bit_i,
    output logic [BYTE_W-1:0]    dout,
    output logic [BYTE_W-1:0]    dout_en
);

    logic ser_bit_w;

    assign ser_bit_w = byte_i[LAST_BIT - bit_i];

    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        if (g == 0) begin : g_lane0
            assign dout_en[g] = active_i;
            assign dout[g]    = active_i &&
                                ((mode_i == MODE_PAR) ? byte_i[g] : ser_bit_w);
        end else begin : g_laneN
            assign dout_en[g] = active_i && (mode_i == MODE_PAR);
            assign dout[g]    = active_i && (mode_i == MODE_PAR) && byte_i[g];
        end
    end

endmodule

// File: rtl/cfgrd_top.sv
module cfgrd_top
    import cfgrd_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int MUL   = 37,
    parameter int SEED  = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_rst_n,
    input  logic              mode_wr,
    input  logic              mode_par,
    output logic [BYTE_W-1:0] dout,
    output logic [BYTE_W-1:0] dout_en,
    output logic              ceo_n
);

    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

    logic [AW-1:0]        addr_w;
    logic [BIT_CNT_W-1:0] bit_w;
    out_mode_e            mode_w;
    logic                 active_w;
    logic [BYTE_W-1:0]    byte_w;

    cfgrd_seq #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_rst_n (oe_rst_n),
        .mode_wr  (mode_wr),
        .mode_par (mode_par),
        .addr_o   (addr_w),
        .bit_o    (bit_w),
        .mode_o   (mode_w),
        .active_o (active_w),
        .ceo_n    (ceo_n)
    );

    cfgrd_rom #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .MUL   (MUL),
        .SEED  (SEED)
    ) rom_i (
        .addr_i (addr_w),
        .data_o (byte_w)
    );

    cfgrd_outmux mux_i (
        .mode_i   (mode_w),
        .active_i (active_w),
        .byte_i   (byte_w),
        .bit_i    (bit_w),
        .dout     (dout),
        .dout_en  (dout_en)
    );

endmodule

// File: rtl/cfgrd_chk.sv
module cfgrd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_rst_n,
    input logic [7:0] dout_en,
    input logic       ceo_n
);

    AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (dout_en == 8'h00 && ceo_n)) // R3
        else $error("standby with lanes enabled");

    AST_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_rst_n |-> (dout_en == 8'h00 && ceo_n)) // R2
        else $error("reset input low with lanes enabled");

    AST_HANDOFF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !ceo_n |-> (dout_en == 8'h00)) // R5
        else $error("drives bus while passing enable on");

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ceo_n && !ce_n && oe_rst_n) |=> (ce_n || !oe_rst_n || !ceo_n)) // R6
        else $error("counter left terminal state");

    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en == 8'h00 || dout_en == 8'h01 || dout_en == 8'hFF)) // R7
        else $error("illegal lane mask");

    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_rst_n && $past(oe_rst_n) && dout_en != 8'h00 && $past(dout_en) != 8'h00)
            |-> (dout_en == $past(dout_en))) // R10
        else $error("mode changed while output enabled");

endmodule

bind cfgrd_top cfgrd_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_rst_n (oe_rst_n),
    .dout_en  (dout_en),
    .ceo_n    (ceo_n)
);

// File: tb/cfgrd_top_tb_top.sv
`timescale 1ns/1ps
module cfgrd_top_tb_top;

    localparam int DEPTH  = 16;
    localparam int MUL    = 37;
    localparam int SEED_A = 90;
    localparam int SEED_B = 195;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1;
    logic oe = 1'b0;
    logic mwr = 1'b0;
    logic mpar = 1'b0;
    logic [7:0] d1, e1, d2, e2;
    logic ceo1, ceo2;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfgrd_top #(.DEPTH(DEPTH), .MUL(MUL), .SEED(SEED_A)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_rst_n(oe),
        .mode_wr(mwr), .mode_par(mpar), .dout(d1), .dout_en(e1), .ceo_n(ceo1)
    );

    cfgrd_top #(.DEPTH(DEPTH), .MUL(MUL), .SEED(SEED_B)) dut2_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ceo1), .oe_rst_n(oe),
        .mode_wr(mwr), .mode_par(mpar), .dout(d2), .dout_en(e2), .ceo_n(ceo2)
    );

    function automatic logic [7:0] rom_val(int seed, int a);
        return 8'((a * MUL + seed) % 256);
    endfunction

    function automatic logic [7:0] item(int seed, int idx, bit par);
        logic [7:0] b;
        if (par) return rom_val(seed, idx);
        b = rom_val(seed, idx / 8);
        return {7'b0, b[7 - (idx % 8)]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    function automatic logic [7:0] bus();
        return (d1 & e1) | (d2 & e2);
    endfunction

    task automatic expect_chain(string tag, int k, bit par);
        int n = par ? DEPTH : DEPTH * 8;
        logic [7:0] lane = par ? 8'hFF : 8'h01;
        logic [7:0] x1 = 8'h00;
        logic [7:0] x2 = 8'h00;
        logic [7:0] xb = 8'h00;
        if (k < n) begin
            x1 = lane;
            xb = item(SEED_A, k, par);
        end else if (k < 2 * n) begin
            x2 = lane;
            xb = item(SEED_B, k - n, par);
        end
        chk({tag, " R1 R7 R8 lanes first"}, e1, x1);
        chk({tag, " R5 lanes second"}, e2, x2);
        chk({tag, " R11 bus value"}, bus(), xb);
        chk({tag, " R4 R5 ceo first"}, ceo1, (k >= n) ? 0 : 1);
        chk({tag, " R6 ceo second"}, ceo2, (k >= 2 * n) ? 0 : 1);
    endtask

    task automatic restart();
        oe = 1'b0;
        tick();
        oe = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state
        #1;
        chk("R9 reset lanes", e1, 8'h00);
        chk("R2 reset ceo", ceo1, 1);
        tick();
        tick();
        rst_n = 1'b1;
        tick();

        // serial sweep across both chained devices
        ce_n = 1'b0;
        oe = 1'b1;
        for (int k = 0; k <= 2 * DEPTH * 8 + 3; k++) begin
            settle();
            expect_chain("serial", k, 1'b0);
            tick();
        end

        // mode load while output enabled: ignored
        mwr = 1'b1;
        mpar = 1'b1;
        tick();
        mwr = 1'b0;
        oe = 1'b0;
        settle();
        chk("R2 oe low lanes", e1, 8'h00);
        chk("R2 oe low ceo high", ceo1, 1);
        tick();
        oe = 1'b1;
        settle();
        chk("R2 ceo high after oe return", ceo1, 1);
        chk("R10 ignored load keeps serial", e1, 8'h01);
        chk("R2 cleared to first bit", bus(), item(SEED_A, 0, 1'b0));
        tick();

        // select parallel mode
        oe = 1'b0;
        mwr = 1'b1;
        mpar = 1'b1;
        tick();
        mwr = 1'b0;
        oe = 1'b1;
        for (int k = 0; k <= 2 * DEPTH + 3; k++) begin
            settle();
            expect_chain("parallel", k, 1'b1);
            tick();
        end

        // standby mid-stream
        restart();
        repeat (5) tick();
        settle();
        chk("R1 five bytes", bus(), rom_val(SEED_A, 5));
        ce_n = 1'b1;
        settle();
        chk("R3 standby lanes first", e1, 8'h00);
        chk("R3 standby lanes second", e2, 8'h00);
        chk("R3 standby ceo", ceo1, 1);
        tick();
        tick();
        ce_n = 1'b0;
        settle();
        chk("R3 standby cleared", bus(), rom_val(SEED_A, 0));
        chk("R8 parallel lanes", e1, 8'hFF);
        tick();
        tick();
        tick();
        settle();
        chk("R1 three steps", bus(), rom_val(SEED_A, 3));
        oe = 1'b0;
        settle();
        chk("R2 oe low mid-stream", e1, 8'h00);
        tick();
        oe = 1'b1;
        settle();
        chk("R2 oe cleared", bus(), rom_val(SEED_A, 0));

        // back to serial
        tick();
        oe = 1'b0;
        mwr = 1'b1;
        mpar = 1'b0;
        tick();
        mwr = 1'b0;
        oe = 1'b1;
        settle();
        chk("R10 serial reloaded", e1, 8'h01);
        chk("R7 msb first", bus(), item(SEED_A, 0, 1'b0));
        repeat (9) tick();
        settle();
        chk("R7 word step after bit 7", bus(), item(SEED_A, 9, 1'b0));

        // power-on reset returns to serial
        tick();
        oe = 1'b0;
        mwr = 1'b1;
        mpar = 1'b1;
        tick();
        mwr = 1'b0;
        oe = 1'b1;
        tick();
        tick();
        settle();
        chk("R8 parallel before reset", bus(), rom_val(SEED_A, 2));
        rst_n = 1'b0;
        settle();
        chk("R9 reset selects serial", e1, 8'h01);
        chk("R9 reset clears counter", bus(), item(SEED_A, 0, 1'b0));
        tick();
        rst_n = 1'b1;
        tick();
        settle();
        chk("R9 serial after reset", bus(), item(SEED_A, 1, 1'b0));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule